// File: doc/BRIEF.md
# Byte-Serial Shared AES State Register

This block keeps the sixteen-byte AES state as `NSHARES` Boolean shares per byte. The true value of a byte is the XOR of its shares. Internally the state is a chain of shared-byte registers. The chain is walked row by row, so one shared byte leaves at the head each cycle and goes to an external key-addition and substitution path. One processed shared byte enters at the tail in the same cycle.

Two further operations act on all shares with no randomness:

- **ShiftRows.** The rows are rotated in one cycle by alternate register routing.
- **Column mixing.** Four single-cycle passes are made, each through one combinational column mixer per share.

The surrounding controller does three things:

- It drives the operation code.
- It stalls the chain while the shared substitution unit is busy with key bytes.
- It raises a last-round flag. This flag suppresses column mixing and marks the final key-addition pass.

The shared ciphertext output stays at zero until that final pass has written all sixteen bytes. This keeps intermediate shares from reaching the output.

Top module: `shared_state_holder`

## Requirements
- R1: Reset clears every share of every byte and drives `ct_o` to zero. A cycle with `load_i` high writes `pt_i` into share 0 and zero into all other shares. Byte b of the plaintext is `pt_i[8b+7:8b]`. The load also clears the round-end tracking, so `ct_o` reads zero in the next cycle.
- R2: `dout_o` always holds the shares of the byte at the head of the chain. Share s sits at `dout_o[8s+7:8s]`. Byte b occupies bits `[128s+8b+7:128s+8b]` of share s. Successive shift cycles present the bytes in the order 0,4,8,12,1,5,9,13,2,6,10,14,3,7,11,15.
- R3: A shift cycle is `op_i` = 2'b01 with `stall_i` low. It moves every byte one place toward the head and writes `din_i` into byte 15. After sixteen shift cycles, the k-th written byte lies at the k-th position of the R2 order.
- R4: While `stall_i` is high and `load_i` is low, the state, the column counter and the round-end counter all keep their values, and `din_i` is not written.
- R5: `op_i` = 2'b10 performs ShiftRows in one cycle on each share. Row r is rotated left by r byte positions, and row 0 is unchanged.
- R6: `op_i` = 2'b11 with `last_i` low replaces one column of every share with its image under multiplication by 03x^3+01x^2+01x+02 mod x^4+1 over GF(2^8). The columns are taken in the order 0,1,2,3 and then wrap. The column counter restarts at 0 on load.
- R7: All operations act share by share and linearly. A complete ten-round encryption therefore gives a recombined `ct_o` equal to the AES-128 ciphertext, even with random masks on the incoming bytes.
- R8: A column-mixing request made while `last_i` is high leaves the state and the column counter unchanged.
- R9: `ct_o` reads zero until sixteen shift cycles with `last_i` high have completed since the last load. From then on it carries all shares of the state, with share s at `[128s+127:128s]`.
- R10: `load_i` takes priority over `stall_i` and over every operation code. `op_i` = 2'b00 holds the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load plaintext as a trivial sharing |
| pt_i | input | 128 | Unshared plaintext, byte b at [8b+7:8b] |
| op_i | input | 2 | 00 hold, 01 shift, 10 ShiftRows, 11 column mix |
| stall_i | input | 1 | Freeze the state and counters |
| last_i | input | 1 | Last-round flag |
| din_i | input | 8*NSHARES | Shared byte written at the tail |
| dout_o | output | 8*NSHARES | Shared byte at the head |
| ct_o | output | 128*NSHARES | Gated shared ciphertext |

## Verification
The critical coincidence is a stall arriving in the same cycle as the shift that would complete the final key-addition pass. If the round-end counter were not frozen by the stall, the output gate would open with one byte still stale. The bench requests the sixteenth last-round shift with `stall_i` high and drives a garbage byte on `din_i`. It then requires `ct_o` to remain zero. Only after the un-stalled shift does it require `ct_o` to match the AES known-answer ciphertext and the bench's shared model.

A second coincidence is also exercised. A load is issued together with a stalled shift, and the full state is then read out through the chain to confirm the load alone took effect.

// File: rtl/shst_pkg.sv
package shst_pkg;

  localparam int unsigned NBYTES = 16;
  localparam int unsigned NCOLS  = 4;
  localparam int unsigned SHW    = 8 * NBYTES;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_SROW  = 2'b10,
    OP_MIX   = 2'b11
  } op_e;

  // GF(2^8) doubling, reduction polynomial x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // chain position p (row-major walk) -> column-major byte index
  function automatic int unsigned walk_byte(input int unsigned p);
    return (p % NCOLS) * 4 + p / NCOLS;
  endfunction

endpackage

// File: rtl/shst_mixcol.sv
module shst_mixcol #(
  parameter int NSHARES = 2
) (
  input  logic [NSHARES*32-1:0] col_i,
  output logic [NSHARES*32-1:0] col_o
);
  import shst_pkg::*;

  for (genvar s = 0; s < NSHARES; s++) begin : g_share
    logic [7:0] a0, a1, a2, a3;
    assign a0 = col_i[s*32 +  0 +: 8];
    assign a1 = col_i[s*32 +  8 +: 8];
    assign a2 = col_i[s*32 + 16 +: 8];
    assign a3 = col_i[s*32 + 24 +: 8];
    assign col_o[s*32 +  0 +: 8] = gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3;
    assign col_o[s*32 +  8 +: 8] = a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3;
    assign col_o[s*32 + 16 +: 8] = a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3;
    assign col_o[s*32 + 24 +: 8] = gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3);
  end

endmodule

// File: rtl/shst_rowshift.sv
module shst_rowshift #(
  parameter int NSHARES = 2
) (
  input  logic [NSHARES*128-1:0] st_i,
  output logic [NSHARES*128-1:0] st_o
);
  for (genvar s = 0; s < NSHARES; s++) begin : g_share
    for (genvar r = 0; r < 4; r++) begin : g_row
      for (genvar c = 0; c < 4; c++) begin : g_col
        localparam int DST = 4 * c + r;
        localparam int SRC = 4 * ((c + r) % 4) + r;
        assign st_o[s*128 + DST*8 +: 8] = st_i[s*128 + SRC*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/shst_seqctl.sv
module shst_seqctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] op_i,
  input  logic       stall_i,
  input  logic       last_i,
  output logic       upd_shift_o,
  output logic       upd_srow_o,
  output logic       upd_mix_o,
  output logic [1:0] col_o,
  output logic       done_o
);
  import shst_pkg::*;

  localparam int CW = $clog2(NCOLS);
  localparam int BW = $clog2(NBYTES);

  op_e             op;
  logic            go;
  logic [CW-1:0]   col_q, col_d;
  logic [BW-1:0]   lrc_q, lrc_d;
  logic            done_q, done_d;
  logic            col_en, lrc_en;

  assign op = op_e'(op_i);

  always_comb begin
    go          = !load_i && !stall_i;
    upd_shift_o = go && (op == OP_SHIFT);
    upd_srow_o  = go && (op == OP_SROW);
    upd_mix_o   = go && (op == OP_MIX) && !last_i;
  end

  always_comb begin
    col_en = load_i || upd_mix_o;
    col_d  = load_i ? '0 : col_q + 1'b1;
    lrc_en = load_i || (upd_shift_o && last_i);
    lrc_d  = load_i ? '0 : lrc_q + 1'b1;
    done_d = done_q;
    if (load_i)
      done_d = 1'b0;
    else if (upd_shift_o && last_i && (lrc_q == BW'(NBYTES - 1)))
      done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      lrc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (col_en) col_q <= col_d;
      if (lrc_en) lrc_q <= lrc_d;
      done_q <= done_d;
    end
  end

  assign col_o  = col_q;
  assign done_o = done_q;

  AST_DONE_AFTER_FINAL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(last_i && !stall_i && !load_i && (op_i == 2'b01))); // R9
  AST_STALL_FREEZES_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !load_i) |=> ($stable(col_q) && $stable(lrc_q) && $stable(done_q))); // R4
  AST_LAST_BLOCKS_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && !load_i) |=> $stable(col_q)); // R8

endmodule

// File: rtl/shared_state_holder.sv
module shared_state_holder #(
  parameter int NSHARES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [127:0]          pt_i,
  input  logic [1:0]            op_i,
  input  logic                  stall_i,
  input  logic                  last_i,
  input  logic [NSHARES*8-1:0]  din_i,
  output logic [NSHARES*8-1:0]  dout_o,
  output logic [NSHARES*128-1:0] ct_o
);
  import shst_pkg::*;

  localparam int W = NSHARES * SHW;

  logic [W-1:0]            st_q, st_d, st_sr;
  logic                    st_en;
  logic [NSHARES*32-1:0]   mix_in, mix_out;
  logic                    upd_shift, upd_srow, upd_mix, done;
  logic [1:0]              col;
  logic [NSHARES*8-1:0]    head_next;
  logic [NSHARES*32-1:0]   row0_v;

  shst_seqctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .op_i       (op_i),
    .stall_i    (stall_i),
    .last_i     (last_i),
    .upd_shift_o(upd_shift),
    .upd_srow_o (upd_srow),
    .upd_mix_o  (upd_mix),
    .col_o      (col),
    .done_o     (done)
  );

  shst_rowshift #(.NSHARES(NSHARES)) u_rows (
    .st_i(st_q),
    .st_o(st_sr)
  );

  shst_mixcol #(.NSHARES(NSHARES)) u_mix (
    .col_i(mix_in),
    .col_o(mix_out)
  );

  always_comb begin
    for (int s = 0; s < NSHARES; s++)
      mix_in[s*32 +: 32] = st_q[s*SHW + 32*int'(col) +: 32];
  end

  // next-state selection
  always_comb begin
    st_d  = st_q;
    st_en = load_i || upd_shift || upd_srow || upd_mix;
    if (load_i) begin
      st_d = '0;
      st_d[SHW-1:0] = pt_i;
    end else if (upd_shift) begin
      for (int s = 0; s < NSHARES; s++) begin
        for (int unsigned p = 0; p < NBYTES - 1; p++)
          st_d[s*SHW + 8*walk_byte(p) +: 8] = st_q[s*SHW + 8*walk_byte(p + 1) +: 8];
        st_d[s*SHW + 8*walk_byte(NBYTES - 1) +: 8] = din_i[s*8 +: 8];
      end
    end else if (upd_srow) begin
      st_d = st_sr;
    end else if (upd_mix) begin
      for (int s = 0; s < NSHARES; s++)
        st_d[s*SHW + 32*int'(col) +: 32] = mix_out[s*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= '0;
    else if (st_en)
      st_q <= st_d;
  end

  for (genvar s = 0; s < NSHARES; s++) begin : g_tap
    assign dout_o[s*8 +: 8]    = st_q[s*SHW +: 8];
    assign head_next[s*8 +: 8] = st_q[s*SHW + 8*walk_byte(1) +: 8];
    for (genvar c = 0; c < 4; c++) begin : g_r0
      assign row0_v[(s*4+c)*8 +: 8] = st_q[s*SHW + c*32 +: 8];
    end
  end

  assign ct_o = st_q & {W{done}};

  AST_LOAD_BLANKS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ct_o == '0)); // R1
  AST_SHIFT_ADVANCES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !stall_i && (op_i == 2'b01)) |=> (dout_o == $past(head_next))); // R2
  AST_STALL_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !load_i) |=> $stable(st_q)); // R4
  AST_SROW_KEEPS_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !stall_i && (op_i == 2'b10)) |=> $stable(row0_v)); // R5
  AST_LAST_MIX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !stall_i && last_i && (op_i == 2'b11)) |=> $stable(st_q)); // R8

endmodule

// File: tb/shared_state_holder_test.sv
module shared_state_holder_test;
  localparam int NS = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_i = 1'b0;
  logic [127:0]      pt_i = '0;
  logic [1:0]        op_i = 2'b00;
  logic              stall_i = 1'b0;
  logic              last_i = 1'b0;
  logic [NS*8-1:0]   din_i = '0;
  logic [NS*8-1:0]   dout_o;
  logic [NS*128-1:0] ct_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [NS][16];
  logic [7:0] rk [11][16];
  int mc_col = 0;

  always #4 clk = ~clk;

  shared_state_holder #(.NSHARES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .pt_i(pt_i), .op_i(op_i),
    .stall_i(stall_i), .last_i(last_i), .din_i(din_i), .dout_o(dout_o), .ct_o(ct_o)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wb(input int p);
    return (p % 4) * 4 + p / 4;
  endfunction

  function automatic logic [7:0] x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ aa;
      aa = x2(aa);
    end
    return r;
  endfunction

  function automatic logic [7:0] rol8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h01;
    for (int i = 0; i < 254; i++) inv = gmul(inv, a);
    return inv ^ rol8(inv, 1) ^ rol8(inv, 2) ^ rol8(inv, 3) ^ rol8(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] recomb(input logic [NS*8-1:0] v);
    logic [7:0] r = 8'h00;
    for (int s = 0; s < NS; s++) r = r ^ v[s*8 +: 8];
    return r;
  endfunction

  task automatic key_expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sbox(t[31:24]) ^ rc, sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0])};
        rc = x2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++)
      for (int b = 0; b < 16; b++)
        rk[r][b] = w[4*r + b/4][31 - 8*(b%4) -: 8];
  endtask

  task automatic do_load(input logic [127:0] pt);
    pt_i = pt; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 16; b++) mdl[s][b] = (s == 0) ? pt[8*b +: 8] : 8'h00;
    mc_col = 0;
    chk(ct_o == '0, "R1 ct zero after load", 256'(ct_o), 256'(0));
  endtask

  // recirculating readout: walks the chain once, leaving state unchanged
  task automatic readout(input string req);
    logic [NS*8-1:0] e;
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < NS; s++) e[s*8 +: 8] = mdl[s][wb(p)];
      chk(dout_o == e, req, 256'(dout_o), 256'(e));
      din_i = dout_o; op_i = 2'b01;
      @(negedge clk);
    end
    op_i = 2'b00;
  endtask

  // mode 0: random bytes, 1: sbox(x ^ rk[ri]), 2: x ^ rk[ri]
  task automatic pass(input int mode, input int ri, input bit lst);
    logic [7:0] x, v, m;
    logic [NS*8-1:0] d;
    for (int p = 0; p < 16; p++) begin
      if (p % 5 == 2) begin
        stall_i = 1'b1; op_i = 2'b01; last_i = lst; din_i = NS*8'($urandom);
        @(negedge clk);
        stall_i = 1'b0;
      end
      x = recomb(dout_o);
      case (mode)
        0: v = 8'($urandom);
        1: v = sbox(x ^ rk[ri][wb(p)]);
        default: v = x ^ rk[ri][wb(p)];
      endcase
      d = '0;
      for (int s = 1; s < NS; s++) begin
        m = 8'($urandom); d[s*8 +: 8] = m; v = v ^ m;
      end
      d[7:0] = v;
      for (int s = 0; s < NS; s++) mdl[s][wb(p)] = d[s*8 +: 8];
      if (lst && p == 15) begin
        stall_i = 1'b1; op_i = 2'b01; last_i = 1'b1; din_i = ~d;
        @(negedge clk);
        stall_i = 1'b0;
        chk(ct_o == '0, "R9 stalled final shift keeps ct gated", 256'(ct_o), 256'(0));
      end
      if (lst) chk(ct_o == '0, "R9 ct zero before final pass ends", 256'(ct_o), 256'(0));
      din_i = d; op_i = 2'b01; last_i = lst;
      @(negedge clk);
    end
    op_i = 2'b00; last_i = 1'b0;
  endtask

  task automatic do_sr();
    logic [7:0] t [NS][16];
    op_i = 2'b10;
    @(negedge clk);
    op_i = 2'b00;
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) t[s][4*c + r] = mdl[s][4*((c + r) % 4) + r];
    mdl = t;
  endtask

  task automatic do_mc(input bit stall_first);
    logic [7:0] a [4];
    if (stall_first) begin
      stall_i = 1'b1; op_i = 2'b11;
      @(negedge clk);
      stall_i = 1'b0;
    end
    op_i = 2'b11;
    @(negedge clk);
    op_i = 2'b00;
    for (int s = 0; s < NS; s++) begin
      for (int r = 0; r < 4; r++) a[r] = mdl[s][4*mc_col + r];
      mdl[s][4*mc_col+0] = gmul(a[0], 2) ^ gmul(a[1], 3) ^ a[2] ^ a[3];
      mdl[s][4*mc_col+1] = a[0] ^ gmul(a[1], 2) ^ gmul(a[2], 3) ^ a[3];
      mdl[s][4*mc_col+2] = a[0] ^ a[1] ^ gmul(a[2], 2) ^ gmul(a[3], 3);
      mdl[s][4*mc_col+3] = gmul(a[0], 3) ^ a[1] ^ a[2] ^ gmul(a[3], 2);
    end
    mc_col = (mc_col + 1) % 4;
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] ptv, ctv, pt_le, ct_rec;
    logic [NS*128-1:0] em;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(dout_o == '0, "R1 reset head zero", 256'(dout_o), 256'(0));
    chk(ct_o == '0, "R1 reset ct zero", 256'(ct_o), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // load and walk order
    do_load({4{32'($urandom)}} ^ 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0);
    readout("R2 walk order after load (R1 trivial sharing)");

    // masked random write pass with stalls
    pass(0, 0, 1'b0);
    readout("R3 R4 tail write and stall");

    // ShiftRows, then mixing in two halves
    do_sr();
    readout("R5 ShiftRows");
    do_mc(1'b0); do_mc(1'b1);
    readout("R6 first two columns");
    do_mc(1'b1); do_mc(1'b0);
    readout("R6 last two columns");

    // hold code and load priority over stalled shift
    op_i = 2'b00; din_i = '1;
    repeat (3) @(negedge clk);
    readout("R10 hold keeps state");
    stall_i = 1'b1; op_i = 2'b01;
    ptv = 128'h00112233445566778899aabbccddeeff;
    do_load(ptv);
    stall_i = 1'b0; op_i = 2'b00;
    readout("R10 load wins over stall");

    // full encryption on the standard known-answer vector
    key_expand(128'h000102030405060708090a0b0c0d0e0f);
    for (int b = 0; b < 16; b++) pt_le[8*b +: 8] = ptv[127 - 8*b -: 8];
    do_load(pt_le);
    for (int r = 1; r <= 10; r++) begin
      pass(1, r - 1, 1'b0);
      do_sr();
      if (r < 10) begin
        do_mc(r % 3 == 0); do_mc(1'b0); do_mc(r % 2 == 0); do_mc(1'b0);
      end
    end
    last_i = 1'b1; op_i = 2'b11;
    repeat (4) @(negedge clk);
    last_i = 1'b0; op_i = 2'b00;
    readout("R8 mixing ignored in last round");
    pass(2, 10, 1'b1);
    ctv = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    ct_rec = '0;
    for (int s = 0; s < NS; s++) ct_rec = ct_rec ^ ct_o[s*128 +: 128];
    for (int b = 0; b < 16; b++) pt_le[8*b +: 8] = ctv[127 - 8*b -: 8];
    chk(ct_rec == pt_le, "R7 recombined ciphertext", 256'(ct_rec), 256'(pt_le));
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 16; b++) em[s*128 + 8*b +: 8] = mdl[s][b];
    chk(ct_o == em, "R9 ct shares released after final pass", 256'(ct_o), 256'(em));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule